// File: doc/BRIEF.md
# Signed-Magnitude Pulse-Width Row Driver

This block turns a vector of signed input words into per-row pulse commands for one shared read window. Every row holds an 8-bit signed-magnitude word. The 7-bit magnitude sets how many clock cycles the row's drive pulse lasts. The sign bit chooses which of two drive levels the row uses, so the row's contribution is either added to or subtracted from the column sum. Positive and negative rows are all driven inside the same modulation window. There is no separate phase for the sign. Only the digital timing and the polarity control are modelled here. The analog level generation sits outside the block.

Software or a sequencer loads the vector while the block is idle and then pulses the start input. On the cycle after start, every row with a non-zero magnitude raises its enable at the same time. Each enable falls once its own count of cycles has passed. A timestamp output numbers each cycle of the window, so that downstream accumulators can tell which cycles belong to it. A one-cycle completion flag closes the window, and the block then goes back to idle.

The sequencer has three states. IDLE accepts loads and start, and leaves on start (transition IDLE→DRIVE). DRIVE runs the timestamp from 0 to 127 and leaves when the timestamp reaches its last value (DRIVE→DONE). DONE raises the completion flag for one cycle and always returns (DONE→IDLE).

Top module: `pwmrd_row_driver`

## Requirements
- R1: After reset the block is in IDLE: row_en_o, row_pol_o, win_act_o and done_o are all 0, and the stored vector is all zero, so a window started without any load drives no row.
- R2: When load_i is high in IDLE, vec_i is captured as the stored vector. A load_i pulse while the window is running or while done_o is high leaves the stored vector unchanged.
- R3: A start_i pulse sampled in IDLE opens the window on the next cycle. win_act_o is then high for exactly 128 cycles, and tstamp_o steps by one each cycle from 0 to 127.
- R4: Row i takes its word from vec_i[8i+7:8i], with the magnitude in bits [8i+6:8i]. Its row_en_o bit is high in exactly the window cycles whose tstamp_o is below the magnitude. That gives a pulse of magnitude cycles that starts in the first window cycle. The bit is never high outside the window.
- R5: A row with magnitude 0 never raises its enable, whether its sign bit (bit 8i+7) is 0 or 1.
- R6: Bit 8i+7 is the sign. row_pol_o[i] is 1 (high level, current subtracted) when the sign is 1 and the row is enabled. It is 0 (low level, current added) for a positive row and whenever the row is not enabled.
- R7: done_o is high for exactly one cycle, the cycle right after the window cycle with tstamp_o = 127 (the 129th cycle after start was sampled). win_act_o is low in that cycle, and the block is in IDLE on the next cycle.
- R8: A start_i pulse while the window is running or while done_o is high is ignored. The window keeps its length and timestamps, and no new window follows.
- R9: If load_i and start_i are both high in the same IDLE cycle, the window that opens uses the vector loaded in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture vec_i (accepted in IDLE only) |
| vec_i | input | 64 | Packed signed-magnitude words, row i in bits [8i+7:8i] |
| start_i | input | 1 | Start strobe (accepted in IDLE only) |
| row_en_o | output | 8 | Per-row pulse enable |
| row_pol_o | output | 8 | Per-row drive level: 1 = high (subtract), 0 = low (add) |
| tstamp_o | output | 7 | Cycle index inside the window |
| win_act_o | output | 1 | High for the 128 window cycles |
| done_o | output | 1 | One-cycle window-complete flag |

## Verification
Two pairs of functions can collide in the same cycle. The first pair is a vector load and the start of a window. The second pair is a start strobe and a window that is still running or just ending. The bench drives load_i and start_i together in one idle cycle and expects every row pulse in the next window to match the new vector, not the old one. It also pulses start_i and load_i in the middle of a window and again on the done cycle. It then expects the window to run its normal 128 cycles with the old vector, expects idle to follow, and expects the next window, started without a load, to repeat the original pulses.

// File: rtl/pwmrd_pkg.sv
package pwmrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/pwmrd_seq.sv
module pwmrd_seq
    import pwmrd_pkg::*;
#(
    parameter int MAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [MAG_W-1:0] tstamp_o,
    output logic             win_act_o,
    output logic             done_o,
    output logic             idle_o
);

    localparam logic [MAG_W-1:0] LAST_TS = '1;

    seq_state_t       state_q, state_d;
    logic [MAG_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start_i) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (cnt_q == LAST_TS) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        win_act_o = 1'b0;
        done_o    = 1'b0;
        idle_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle_o    = 1'b1;
            ST_DRIVE: win_act_o = 1'b1;
            ST_DONE:  done_o    = 1'b1;
            default:  idle_o    = 1'b0;
        endcase
        tstamp_o = cnt_q;
    end

endmodule

// File: rtl/pwmrd_vec_reg.sv
module pwmrd_vec_reg #(
    parameter int VEC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VEC_W-1:0] vec_i,
    output logic [VEC_W-1:0] vec_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)     vec_o <= '0;
        else if (wr_en) vec_o <= vec_i;
    end

endmodule

// File: rtl/pwmrd_row_cmp.sv
module pwmrd_row_cmp #(
    parameter int MAG_W = 7
) (
    input  logic [MAG_W:0]   word_i,
    input  logic             win_act_i,
    input  logic [MAG_W-1:0] tstamp_i,
    output logic             en_o,
    output logic             pol_o
);

    logic [MAG_W-1:0] mag;
    logic             neg;

    always_comb begin
        mag   = word_i[MAG_W-1:0];
        neg   = word_i[MAG_W];
        en_o  = win_act_i && (tstamp_i < mag);
        pol_o = en_o && neg;
    end

endmodule

// File: rtl/pwmrd_row_driver.sv
module pwmrd_row_driver #(
    parameter int ROWS  = 8,
    parameter int MAG_W = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [ROWS*(MAG_W+1)-1:0]    vec_i,
    input  logic                         start_i,
    output logic [ROWS-1:0]              row_en_o,
    output logic [ROWS-1:0]              row_pol_o,
    output logic [MAG_W-1:0]             tstamp_o,
    output logic                         win_act_o,
    output logic                         done_o
);

    localparam int WORD_W = MAG_W + 1;
    localparam int VEC_W  = ROWS * WORD_W;

    logic             idle;
    logic [VEC_W-1:0] vec_q;

    pwmrd_seq #(.MAG_W(MAG_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .tstamp_o (tstamp_o),
        .win_act_o(win_act_o),
        .done_o   (done_o),
        .idle_o   (idle)
    );

    pwmrd_vec_reg #(.VEC_W(VEC_W)) u_vec (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(load_i && idle),
        .vec_i(vec_i),
        .vec_o(vec_q)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        pwmrd_row_cmp #(.MAG_W(MAG_W)) u_cmp (
            .word_i   (vec_q[r*WORD_W +: WORD_W]),
            .win_act_i(win_act_o),
            .tstamp_i (tstamp_o),
            .en_o     (row_en_o[r]),
            .pol_o    (row_pol_o[r])
        );
    end

endmodule

// File: rtl/pwmrd_chk.sv
module pwmrd_chk #(
    parameter int ROWS  = 8,
    parameter int MAG_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             win_act,
    input logic             done,
    input logic [MAG_W-1:0] tstamp,
    input logic [ROWS-1:0]  row_en,
    input logic [ROWS-1:0]  row_pol
);

    localparam logic [MAG_W-1:0] LAST_TS = '1;

    p_idle_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_act && !done && start_i) |=> (win_act && tstamp == '0));

    p_tstamp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_act && tstamp != LAST_TS) |=> (win_act && tstamp == MAG_W'($past(tstamp) + 1)));

    p_no_en_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_act |-> (row_en == '0));

    p_no_late_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_act && tstamp != '0) |-> ((row_en & ~$past(row_en)) == '0));

    p_pol_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((row_pol & ~row_en) == '0));

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_act && tstamp == LAST_TS) |=> (done && !win_act));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !win_act));

    p_start_in_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start_i) |=> !win_act);

endmodule

bind pwmrd_row_driver pwmrd_chk #(.ROWS(ROWS), .MAG_W(MAG_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .win_act(win_act_o),
    .done   (done_o),
    .tstamp (tstamp_o),
    .row_en (row_en_o),
    .row_pol(row_pol_o)
);

// File: tb/tb_pwmrd_row_driver.sv
`timescale 1ns/1ps
module tb_pwmrd_row_driver;

    localparam int ROWS  = 8;
    localparam int MAG_W = 7;
    localparam int VW    = ROWS * (MAG_W + 1);
    localparam int WIN   = 1 << MAG_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load = 1'b0;
    logic [VW-1:0]   vec = '0;
    logic            start = 1'b0;
    logic [ROWS-1:0] row_en, row_pol;
    logic [MAG_W-1:0] tstamp;
    logic            win_act, done;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwmrd_row_driver #(.ROWS(ROWS), .MAG_W(MAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .load_i(load), .vec_i(vec), .start_i(start),
        .row_en_o(row_en), .row_pol_o(row_pol), .tstamp_o(tstamp),
        .win_act_o(win_act), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [ROWS-1:0] exp_en(input logic [VW-1:0] v, input int j);
        logic [ROWS-1:0] e;
        for (int r = 0; r < ROWS; r++)
            e[r] = (int'(v[r*8 +: 7]) > j);
        return e;
    endfunction

    function automatic logic [ROWS-1:0] exp_pol(input logic [VW-1:0] v, input int j);
        logic [ROWS-1:0] p;
        for (int r = 0; r < ROWS; r++)
            p[r] = (int'(v[r*8 +: 7]) > j) && v[r*8 + 7];
        return p;
    endfunction

    task automatic do_load(input logic [VW-1:0] v);
        @(negedge clk); load = 1'b1; vec = v;
        @(negedge clk); load = 1'b0;
    endtask

    // Runs one window. pre_load: load ld_val with the start (R9).
    // ld_at / st_at: window cycle for a stray load / start (-1 = none) (R2, R8).
    // st_done: pulse start during the done cycle (R8).
    task automatic run_window(input logic [VW-1:0] exp_vec, input bit pre_load,
                              input int ld_at, input logic [VW-1:0] ld_val,
                              input int st_at, input bit st_done, input string tag);
        bit en_ok = 1'b1, pol_ok = 1'b1, ts_ok = 1'b1;
        @(negedge clk); start = 1'b1;
        if (pre_load) begin load = 1'b1; vec = ld_val; end
        @(negedge clk); start = 1'b0; load = 1'b0;
        for (int j = 0; j < WIN; j++) begin
            if (!(win_act && !done && int'(tstamp) == j)) begin
                if (ts_ok) chk(1'b0, "R3", {tag, " window/tstamp"}, 64'(tstamp), 64'(j));
                ts_ok = 1'b0;
            end
            if (row_en !== exp_en(exp_vec, j)) begin
                if (en_ok) chk(1'b0, "R4/R5", {tag, " row_en"}, 64'(row_en), 64'(exp_en(exp_vec, j)));
                en_ok = 1'b0;
            end
            if (row_pol !== exp_pol(exp_vec, j)) begin
                if (pol_ok) chk(1'b0, "R6", {tag, " row_pol"}, 64'(row_pol), 64'(exp_pol(exp_vec, j)));
                pol_ok = 1'b0;
            end
            load  = (j == ld_at);
            if (j == ld_at) vec = ld_val;
            start = (j == st_at);
            @(negedge clk);
        end
        if (ts_ok)  chk(1'b1, "R3", {tag, " window"}, 0, 0);
        if (en_ok)  chk(1'b1, "R4", {tag, " row_en"}, 0, 0);
        if (pol_ok) chk(1'b1, "R6", {tag, " row_pol"}, 0, 0);
        load = 1'b0;
        start = st_done;
        chk(done === 1'b1 && win_act === 1'b0 && row_en === '0, "R7",
            {tag, " done cycle"}, {62'd0, done, win_act}, 64'd2);
        @(negedge clk); start = 1'b0;
        chk(done === 1'b0 && win_act === 1'b0, "R7/R8", {tag, " after done"},
            {62'd0, done, win_act}, 64'd0);
        @(negedge clk);
        chk(win_act === 1'b0 && row_en === '0, "R8", {tag, " stays idle"},
            64'(row_en), 64'd0);
    endtask

    localparam logic [VW-1:0] P_MIX  = 64'h80_00_FF_7F_01_85_40_02;
    localparam logic [VW-1:0] P_ALT  = 64'hC1_3F_90_0A_8A_03_FE_81;
    localparam logic [VW-1:0] P_NZ   = 64'h80_80_80_80_80_80_80_80;
    localparam logic [VW-1:0] P_RAMP = 64'h11_92_23_B4_45_D6_67_F8;

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(row_en === '0 && row_pol === '0 && win_act === 1'b0 && done === 1'b0,
            "R1", "reset outputs", {row_en, row_pol, 46'd0, win_act, done}, 64'd0);
        run_window('0, 1'b0, -1, '0, -1, 1'b0, "R1 empty vector");
    endtask

    task automatic t_patterns;
        do_load(P_MIX);  run_window(P_MIX,  1'b0, -1, '0, -1, 1'b0, "R2 mixed");
        do_load(P_ALT);  run_window(P_ALT,  1'b0, -1, '0, -1, 1'b0, "R4 alt");
        do_load(P_NZ);   run_window(P_NZ,   1'b0, -1, '0, -1, 1'b0, "R5 neg zero");
        do_load(P_RAMP); run_window(P_RAMP, 1'b0, -1, '0, -1, 1'b0, "R6 ramp");
    endtask

    task automatic t_busy;
        do_load(P_MIX);
        run_window(P_MIX, 1'b0, 40, P_ALT, 60, 1'b1, "R8 stray load/start");
        run_window(P_MIX, 1'b0, -1, '0, -1, 1'b0, "R2 load in window ignored");
    endtask

    task automatic t_same_cycle;
        do_load(P_ALT);
        run_window(P_RAMP, 1'b1, -1, P_RAMP, -1, 1'b0, "R9 load with start");
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_busy();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule